// File: doc/BRIEF.md
# Carrier-gated synchronous serial receiver

This block turns a serial bit stream into parallel words. The bit stream arrives with a bit clock that a remote transmitter supplies. The block never generates that clock. The transmitter also drives a carrier-detect line, which frames the time when it is sending. The receive clock, the data line and the carrier line each pass through a two-flop synchronizer into the system clock domain. The selected edge of the receive clock is then detected there, and one data bit is taken on each such edge, but only while the carrier line is at its active level and receive is enabled. The system clock must run at least four times the receive bit rate.

Bits are packed least significant first into a word of 5 to 8 bits. There are no start, stop or parity bits. A finished word is offered on a valid/ready output port. Back-pressure follows these rules. Once `out_valid` is high, it stays high and `out_data` stays unchanged until a cycle in which `out_ready` is high. The word leaves the port on that cycle. If another word completes while the held word has not yet been taken, the new word is dropped and a sticky `overrun` flag is raised. A word that completes in the same cycle as a handshake takes the freed slot. The carrier polarity, the data polarity and the clock edge can each be chosen.

Top module: `gated_sync_rx`

## Requirements
- R1: After reset, `out_valid` is 0, `overrun` is 0 and `out_data` is 0.
- R2: With `clk_fall`=0, a bit is taken on each rising edge of `rx_clk`. With `clk_fall`=1, a bit is taken on each falling edge instead. The first bit taken lands in bit 0 of the word.
- R3: The word length is 5 + `len_sel`, so 0 gives 5 bits and 3 gives 8 bits. The word is delivered once that many bits have been taken. Bits of `out_data` at and above the word length read 0.
- R4: Clock edges that arrive while the carrier is inactive take no bit and produce no word. The carrier is active when `dcd` equals NOT `dcd_low`.
- R5: With `data_inv`=1, each received bit is the inverse of the `rx_data` level. With `data_inv`=0, it equals the level.
- R6: If the carrier goes inactive before a word is complete, the bits taken so far are discarded. The next word starts again at bit 0.
- R7: While `rx_en` is 0, no bit is taken and no word is delivered.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R9: A word that completes while a held word is not yet taken is dropped. `overrun` then becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| rx_clk | input | 1 | External bit clock, asynchronous to clk |
| rx_data | input | 1 | Serial data, synchronous with rx_clk |
| dcd | input | 1 | Carrier detect from the remote transmitter |
| dcd_low | input | 1 | 1: carrier active low |
| clk_fall | input | 1 | 1: sample on the falling edge of rx_clk |
| data_inv | input | 1 | 1: invert received bits |
| len_sel | input | 2 | Word length minus 5 |
| out_data | output | 8 | Received word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| overrun | output | 1 | Sticky: a word was dropped |

## Verification
Random words are sent with random length, edge choice, carrier polarity and data polarity. This shows that the bit order, the masking of unused bits and each inversion act independently of one another. Some clock bursts are sent with the carrier inactive, and some with receive disabled. In both cases no word may appear, which separates the gating from the edge detection. A carrier that drops partway through a word, followed by a full word, shows whether the partial bits are discarded or leak into the next word. Holding `out_ready` low across two words checks two things: that the held word stays stable, and that the second word is dropped with `overrun` set.

// File: rtl/gated_sync_rx_pkg.sv
package gated_sync_rx_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic int cnt_width(input int max_len);
    return $clog2(max_len + 1);
  endfunction
endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/gsr_edge.sv
module gsr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rclk_s,
  input  logic fall_sel,
  output logic edge_p
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= rclk_s;
  end

  always_comb begin
    if (fall_sel) edge_p = prev & ~rclk_s;
    else          edge_p = ~prev & rclk_s;
  end
endmodule

// File: rtl/gsr_asm.sv
module gsr_asm #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_ok,
  input  logic              sample,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  len,
  output logic [DATA_W-1:0] word_out,
  output logic              done
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] acc, acc_nx;
  logic              last;

  always_comb begin
    acc_nx = acc;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) == cnt) acc_nx[i] = bit_in;
    end
  end

  assign last = (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      acc      <= '0;
      word_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!gate_ok) begin
        cnt <= '0;
        acc <= '0;
      end else if (sample) begin
        if (last) begin
          word_out <= acc_nx;
          done     <= 1'b1;
          cnt      <= '0;
          acc      <= '0;
        end else begin
          acc <= acc_nx;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gated_sync_rx.sv
module gated_sync_rx
  import gated_sync_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_clk,
  input  logic              rx_data,
  input  logic              dcd,
  input  logic              dcd_low,
  input  logic              clk_fall,
  input  logic              data_inv,
  input  logic [SEL_W-1:0]  len_sel,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              overrun
);
  localparam int CNT_W = cnt_width(DATA_W);

  logic [2:0]        raw_in, syn;
  logic              rclk_s, rdat_s, dcd_s;
  logic              edge_p, gate_ok, sample, bit_val;
  logic [CNT_W-1:0]  len;
  logic [DATA_W-1:0] word;
  logic              done;

  assign raw_in = {dcd, rx_data, rx_clk};

  gsr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign rclk_s = syn[0];
  assign rdat_s = syn[1];
  assign dcd_s  = syn[2];

  gsr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rclk_s(rclk_s),
    .fall_sel(clk_fall), .edge_p(edge_p)
  );

  assign gate_ok = rx_en & (dcd_s ^ dcd_low);
  assign sample  = edge_p & gate_ok;
  assign bit_val = rdat_s ^ data_inv;
  assign len     = CNT_W'(MIN_LEN) + CNT_W'(len_sel);

  gsr_asm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .gate_ok(gate_ok), .sample(sample),
    .bit_in(bit_val), .len(len), .word_out(word), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (done) begin
        if (out_valid && !out_ready) begin
          overrun <= 1'b1;
        end else begin
          out_data  <= word;
          out_valid <= 1'b1;
        end
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gated_sync_rx_chk.sv
module gated_sync_rx_chk #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int SEL_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic [SEL_W-1:0]  len_sel,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              overrun
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(out_valid && !out_ready));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (MIN_LEN + int'(len_sel))) == '0));

  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rx_en));
endmodule

bind gated_sync_rx gated_sync_rx_chk #(
  .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .len_sel(len_sel),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .overrun(overrun)
);

// File: tb/gated_sync_rx_tb.sv
module gated_sync_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_en = 0, rx_clk = 0, rx_data = 0, dcd = 0;
  logic       dcd_low = 0, clk_fall = 0, data_inv = 0;
  logic [1:0] len_sel = 0;
  logic [7:0] out_data;
  logic       out_valid, out_ready = 1, overrun;

  int errors = 0, checks = 0;
  int ncap = 0;
  logic [7:0] cap [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_sync_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_clk(rx_clk),
    .rx_data(rx_data), .dcd(dcd), .dcd_low(dcd_low), .clk_fall(clk_fall),
    .data_inv(data_inv), .len_sel(len_sel), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      cap[ncap[7:0]] = out_data;
      ncap++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_word(input logic [7:0] line, input int len, input logic inv);
    logic [7:0] m = 8'((1 << len) - 1);
    return (line ^ {8{inv}}) & m;
  endfunction

  task automatic set_cfg(input logic [1:0] ls, input logic fl, input logic dl, input logic inv);
    dcd = dl;
    len_sel = ls; clk_fall = fl; dcd_low = dl; data_inv = inv;
    rx_clk = fl;
    wait_cyc(8);
  endtask

  task automatic clock_bits(input logic [7:0] line, input int n);
    for (int i = 0; i < n; i++) begin
      rx_data = line[i];
      wait_cyc(HALF_BIT);
      rx_clk = ~clk_fall;
      wait_cyc(HALF_BIT);
      rx_clk = clk_fall;
    end
  endtask

  task automatic frame(input logic [7:0] line, input int n);
    dcd = ~dcd_low;
    wait_cyc(4);
    clock_bits(line, n);
    wait_cyc(4);
    dcd = dcd_low;
    wait_cyc(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    wait_cyc(3);
    check("R1 valid", 32'(out_valid), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 data", 32'(out_data), 0);
    rst_n = 1;
    rx_en = 1;
    wait_cyc(4);

    // Directed: rising edge, 8 bits, LSB first (R2, R3)
    begin
      int n0;
      set_cfg(2'd3, 0, 0, 0);
      n0 = ncap;
      frame(8'hA5, 8);
      check("R2 count", 32'(ncap - n0), 1);
      check("R2 lsb-first", 32'(cap[n0[7:0]]), 32'h A5);
    end

    // Random words over all configurations (R2 R3 R4 R5)
    for (int k = 0; k < 40; k++) begin
      logic [7:0] line = 8'($urandom);
      logic [1:0] ls   = 2'($urandom);
      logic       fl   = 1'($urandom);
      logic       dl   = 1'($urandom);
      logic       inv  = 1'($urandom);
      int n0;
      set_cfg(ls, fl, dl, inv);
      n0 = ncap;
      frame(line, 5 + int'(ls));
      check("R3 count", 32'(ncap - n0), 1);
      check("R5 word", 32'(cap[n0[7:0]]), 32'(expect_word(line, 5 + int'(ls), inv)));
    end

    // Carrier inactive: edges ignored (R4)
    begin
      int n0;
      set_cfg(2'd0, 0, 1, 0);
      n0 = ncap;
      clock_bits(8'hFF, 8);
      wait_cyc(10);
      check("R4 no word", 32'(ncap - n0), 0);
      check("R4 no valid", 32'(out_valid), 0);
      frame(8'h13, 5);
      check("R4 after gate", 32'(cap[n0[7:0]]), 32'h13);
    end

    // Carrier drops mid-word (R6)
    begin
      int n0;
      set_cfg(2'd3, 1, 0, 0);
      n0 = ncap;
      frame(8'hFF, 3);
      check("R6 partial", 32'(ncap - n0), 0);
      frame(8'h3C, 8);
      check("R6 count", 32'(ncap - n0), 1);
      check("R6 word", 32'(cap[n0[7:0]]), 32'h3C);
    end

    // Receive disabled (R7)
    begin
      int n0;
      set_cfg(2'd3, 0, 0, 0);
      rx_en = 0;
      n0 = ncap;
      frame(8'h77, 8);
      check("R7 no word", 32'(ncap - n0), 0);
      rx_en = 1;
      wait_cyc(4);
    end

    // Back-pressure and overrun (R8 R9)
    begin
      int n0;
      set_cfg(2'd3, 0, 0, 0);
      n0 = ncap;
      out_ready = 0;
      frame(8'h5A, 8);
      wait_cyc(20);
      check("R8 held valid", 32'(out_valid), 1);
      check("R8 held data", 32'(out_data), 32'h5A);
      check("R9 no overrun yet", 32'(overrun), 0);
      frame(8'hC3, 8);
      check("R9 overrun", 32'(overrun), 1);
      check("R9 kept first", 32'(out_data), 32'h5A);
      out_ready = 1;
      wait_cyc(3);
      check("R9 one delivered", 32'(ncap - n0), 1);
      check("R9 delivered word", 32'(cap[n0[7:0]]), 32'h5A);
      check("R9 sticky", 32'(overrun), 1);
      check("R8 drained", 32'(out_valid), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule